// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the control port of a pixel-digitising front end. An external host drives three wires (a serial clock, a serial data line and a latch enable) to write and read a small bank of 8-bit configuration registers. The port also has one serial data output. All three inputs are sampled in the master clock domain through a short synchroniser chain. The edges of the synchronised signals then drive everything. A rising edge on the serial clock shifts in one data bit. A falling edge on the serial clock advances the read-back output. A rising edge on the latch enable commits the frame that was shifted in.

A frame has 14 bits: a 6-bit address, then an 8-bit data word, each sent most significant bit first. When address bit 4 is clear, the frame is a write. When address bit 4 is set, the frame is a read-back request: the register at the same address with bit 4 cleared is loaded into an output shifter. Its contents come out on the serial output while the next frame is shifted in. Three further addresses have special meaning: a software reset address, and two broadcast addresses that load the red, green and blue members of a register triplet with one write.

The register contents leave the block as parallel bytes for the rest of the chip. A read-back flag is also provided, so that a pin shared with the data bus can switch to serial read-back while a word is being sent.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame is the last 14 bits sampled on rising serial-clock edges before the commit. The first 6 are the address, MSB first. The last 8 are the data, MSB first.
- R2: Registers change only when a rising edge of the latch enable commits a frame. Shifting bits in leaves every output unchanged.
- R3: After reset, each register holds its default. Addresses and defaults are:
  - control A at 000001 = 0F
  - control B at 000010 = 23
  - control C at 000011 = 1F
  - control D at 000110 = 05
  - control E at 001000 = 00
  - red, green and blue offsets at 100000, 100001 and 100010 = 80
  - red, green and blue gains at 101000, 101001 and 101010 = 00
- R4: A committed frame with address bit 4 set modifies no register.
- R5: A read frame with address bit 4 set loads the register at the same address with bit 4 cleared. The sequence on the serial output is:
  - After the commit, the serial output carries bit 7 of that register.
  - Each later falling serial-clock edge moves the output one bit toward bit 0.
  - The read-back flag is high from the commit until the 8th falling edge.
  - While the flag is low, the serial output is 0.
- R6: A new frame may be shifted in and committed while the previous read-back word is still being sent. The outgoing word is not disturbed.
- R7: Writing any data to address 000100 returns every writable register to its default.
- R8: Writing to 100011 loads all three offset registers with the data. Writing to 101011 loads all three gain registers with the data.
- R9: Address 000111 reads 41. Writes to it have no effect.
- R10: Writes to addresses not listed above are ignored. Reads of those addresses, including 000100, 100011 and 101011, return 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sen | input | 1 | Latch enable; rising edge commits the frame |
| sdo | output | 1 | Serial read-back data |
| rb_active | output | 1 | High while a read-back word is being sent |
| ctl_a | output | 8 | Control register A |
| ctl_b | output | 8 | Control register B |
| ctl_c | output | 8 | Control register C |
| ctl_d | output | 8 | Control register D |
| ctl_e | output | 8 | Control register E |
| ofs_r | output | 8 | Red offset |
| ofs_g | output | 8 | Green offset |
| ofs_b | output | 8 | Blue offset |
| gain_r | output | 8 | Red gain |
| gain_g | output | 8 | Green gain |
| gain_b | output | 8 | Blue gain |

## Verification
The bench builds the port with the default synchroniser depth of two stages. At that depth the whole 6-bit address space is cheap to walk. Every write address with bit 4 clear is written with a distinct value, then all 64 addresses are read back. The reads are chained, so each read-back word comes out while the next read frame is being shifted in. The bench also checks the broadcast, software-reset, read-only and unlisted addresses against a byte-array model, and samples the serial output and the read-back flag at every bit slot.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int SYNC = 2,
  parameter int DW   = 8,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          sdi,
  input  logic          sen,
  output logic          sdo,
  output logic          rb_active,
  output logic [DW-1:0] ctl_a,
  output logic [DW-1:0] ctl_b,
  output logic [DW-1:0] ctl_c,
  output logic [DW-1:0] ctl_d,
  output logic [DW-1:0] ctl_e,
  output logic [DW-1:0] ofs_r,
  output logic [DW-1:0] ofs_g,
  output logic [DW-1:0] ofs_b,
  output logic [DW-1:0] gain_r,
  output logic [DW-1:0] gain_g,
  output logic [DW-1:0] gain_b
);
  localparam int FW = AW + DW;
  localparam int CW = $clog2(DW + 1);
  localparam int RB = 4;

  localparam logic [AW-1:0] A_CTLA = 6'h01, A_CTLB = 6'h02, A_CTLC = 6'h03;
  localparam logic [AW-1:0] A_SRST = 6'h04, A_CTLD = 6'h06, A_REV  = 6'h07;
  localparam logic [AW-1:0] A_CTLE = 6'h08;
  localparam logic [AW-1:0] A_OFR  = 6'h20, A_OFG = 6'h21, A_OFB = 6'h22, A_OFALL = 6'h23;
  localparam logic [AW-1:0] A_GNR  = 6'h28, A_GNG = 6'h29, A_GNB = 6'h2A, A_GNALL = 6'h2B;

  localparam logic [DW-1:0] D_CTLA = 8'h0F, D_CTLB = 8'h23, D_CTLC = 8'h1F;
  localparam logic [DW-1:0] D_CTLD = 8'h05, D_CTLE = 8'h00, D_REV  = 8'h41;
  localparam logic [DW-1:0] D_OFS  = 8'h80, D_GAIN = 8'h00;

  logic [SYNC:0] sck_q, sdi_q, sen_q;
  logic [FW-1:0] frame;
  logic [DW-1:0] rsh, rd_val;
  logic [CW-1:0] rcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      sdi_q <= '0;
      sen_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC-1:0], sck};
      sdi_q <= {sdi_q[SYNC-1:0], sdi};
      sen_q <= {sen_q[SYNC-1:0], sen};
    end

  wire rise_e = sck_q[SYNC-1] & ~sck_q[SYNC];
  wire fall_e = ~sck_q[SYNC-1] & sck_q[SYNC];
  wire commit = sen_q[SYNC-1] & ~sen_q[SYNC];

  wire [AW-1:0] f_addr = frame[FW-1:DW];
  wire [DW-1:0] f_data = frame[DW-1:0];
  wire          f_rd   = f_addr[RB];
  wire [AW-1:0] r_addr = f_addr & ~(AW'(1) << RB);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame <= '0;
    else if (rise_e) frame <= {frame[FW-2:0], sdi_q[SYNC-1]};

  wire do_wr   = commit & ~f_rd;
  wire do_srst = do_wr & (f_addr == A_SRST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || 1'b0) begin
      ctl_a <= D_CTLA; ctl_b <= D_CTLB; ctl_c <= D_CTLC;
      ctl_d <= D_CTLD; ctl_e <= D_CTLE;
      ofs_r <= D_OFS;  ofs_g <= D_OFS;  ofs_b <= D_OFS;
      gain_r <= D_GAIN; gain_g <= D_GAIN; gain_b <= D_GAIN;
    end else if (do_srst) begin
      ctl_a <= D_CTLA; ctl_b <= D_CTLB; ctl_c <= D_CTLC;
      ctl_d <= D_CTLD; ctl_e <= D_CTLE;
      ofs_r <= D_OFS;  ofs_g <= D_OFS;  ofs_b <= D_OFS;
      gain_r <= D_GAIN; gain_g <= D_GAIN; gain_b <= D_GAIN;
    end else if (do_wr) begin
      case (f_addr)
        A_CTLA:  ctl_a  <= f_data;
        A_CTLB:  ctl_b  <= f_data;
        A_CTLC:  ctl_c  <= f_data;
        A_CTLD:  ctl_d  <= f_data;
        A_CTLE:  ctl_e  <= f_data;
        A_OFR:   ofs_r  <= f_data;
        A_OFG:   ofs_g  <= f_data;
        A_OFB:   ofs_b  <= f_data;
        A_OFALL: begin ofs_r <= f_data; ofs_g <= f_data; ofs_b <= f_data; end
        A_GNR:   gain_r <= f_data;
        A_GNG:   gain_g <= f_data;
        A_GNB:   gain_b <= f_data;
        A_GNALL: begin gain_r <= f_data; gain_g <= f_data; gain_b <= f_data; end
        default: ;
      endcase
    end

  always_comb
    case (r_addr)
      A_CTLA:  rd_val = ctl_a;
      A_CTLB:  rd_val = ctl_b;
      A_CTLC:  rd_val = ctl_c;
      A_CTLD:  rd_val = ctl_d;
      A_REV:   rd_val = D_REV;
      A_CTLE:  rd_val = ctl_e;
      A_OFR:   rd_val = ofs_r;
      A_OFG:   rd_val = ofs_g;
      A_OFB:   rd_val = ofs_b;
      A_GNR:   rd_val = gain_r;
      A_GNG:   rd_val = gain_g;
      A_GNB:   rd_val = gain_b;
      default: rd_val = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsh  <= '0;
      rcnt <= '0;
    end else if (commit && f_rd) begin
      rsh  <= rd_val;
      rcnt <= CW'(DW);
    end else if (fall_e && rcnt != '0) begin
      rsh  <= {rsh[DW-2:0], 1'b0};
      rcnt <= rcnt - 1'b1;
    end

  assign rb_active = (rcnt != '0);
  assign sdo       = rb_active & rsh[DW-1];

  a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    commit && f_rd |=> $stable({ctl_a, ctl_b, ctl_c, ctl_d, ctl_e, ofs_r, ofs_g, ofs_b, gain_r, gain_g, gain_b}));

  a_r5_flag_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    commit && f_rd |=> rb_active && sdo == $past(rd_val[DW-1]));

  a_r5_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_active) |-> $past(fall_e));

  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    do_srst |=> ctl_a == D_CTLA && ctl_b == D_CTLB && ofs_g == D_OFS && gain_b == D_GAIN);

  a_r8_ofs_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr && f_addr == A_OFALL |=> ofs_r == $past(f_data) && ofs_g == ofs_r && ofs_b == ofs_r);

  a_r8_gain_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr && f_addr == A_GNALL |=> gain_r == $past(f_data) && gain_g == gain_r && gain_b == gain_r);

  a_r2_hold_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({ctl_a, ctl_b, ctl_c, ctl_d, ctl_e, ofs_r, ofs_g, ofs_b, gain_r, gain_g, gain_b}));
endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
  logic clk = 0, rst_n = 0, sck = 0, sdi = 0, sen = 0;
  logic sdo, rb_active;
  logic [7:0] ctl_a, ctl_b, ctl_c, ctl_d, ctl_e, ofs_r, ofs_g, ofs_b, gain_r, gain_g, gain_b;
  int errors = 0, checks = 0;
  logic [7:0] m [64];

  always #2 clk = ~clk;

  serial_cfg_port u_dut (.clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sen(sen),
    .sdo(sdo), .rb_active(rb_active), .ctl_a(ctl_a), .ctl_b(ctl_b), .ctl_c(ctl_c),
    .ctl_d(ctl_d), .ctl_e(ctl_e), .ofs_r(ofs_r), .ofs_g(ofs_g), .ofs_b(ofs_b),
    .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b));

  function automatic bit writable(input int a);
    return a inside {1, 2, 3, 6, 8, 32, 33, 34, 40, 41, 42};
  endfunction

  task automatic mreset();
    for (int i = 0; i < 64; i++) m[i] = 8'h00;
    m[1] = 8'h0F; m[2] = 8'h23; m[3] = 8'h1F; m[6] = 8'h05; m[8] = 8'h00;
    m[32] = 8'h80; m[33] = 8'h80; m[34] = 8'h80;
  endtask

  task automatic mwrite(input int a, input logic [7:0] d);
    if (a[4]) return;
    if (a == 4) mreset();
    else if (a == 35) begin m[32] = d; m[33] = d; m[34] = d; end
    else if (a == 43) begin m[40] = d; m[41] = d; m[42] = d; end
    else if (writable(a)) m[a] = d;
  endtask

  function automatic logic [7:0] rdval(input int a);
    int b = a & ~16;
    if (b == 7) return 8'h41;
    return writable(b) ? m[b] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_ports(input string req);
    chk(req, ctl_a, m[1]);  chk(req, ctl_b, m[2]);  chk(req, ctl_c, m[3]);
    chk(req, ctl_d, m[6]);  chk(req, ctl_e, m[8]);
    chk(req, ofs_r, m[32]); chk(req, ofs_g, m[33]); chk(req, ofs_b, m[34]);
    chk(req, gain_r, m[40]); chk(req, gain_g, m[41]); chk(req, gain_b, m[42]);
  endtask

  // one frame; when rb_exp_on, the previous read word is captured during bits 0..7
  task automatic frame(input logic [5:0] a, input logic [7:0] d,
                       input bit rb_exp_on, input logic [7:0] rb_exp);
    logic [13:0] bits = {a, d};
    logic [7:0] cap = 8'h00;
    for (int i = 0; i < 14; i++) begin
      sdi = bits[13 - i];
      repeat (8) @(posedge clk);
      @(negedge clk);
      if (i < 8 && rb_exp_on) begin
        cap = {cap[6:0], sdo};
        chk("R5 rb_active during word", {7'd0, rb_active}, 8'd1);
      end
      if (i == 8) begin
        chk("R5 rb_active after 8 falls", {7'd0, rb_active}, 8'd0);
        chk("R5 sdo idle", {7'd0, sdo}, 8'd0);
      end
      sck = 1;
      repeat (8) @(posedge clk);
      sck = 0;
    end
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk_ports("R2 no change before commit");
    sen = 1;
    repeat (8) @(posedge clk);
    sen = 0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    mwrite(a, d);
    chk_ports("R1 R4 R7 R8 R9 R10 ports after commit");
    if (rb_exp_on) chk("R5 R6 R9 R10 read-back word", cap, rb_exp);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit pend;
    logic [7:0] pexp;
    mreset();
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_ports("R3 reset defaults");
    chk("R5 idle flag after reset", {7'd0, rb_active}, 8'd0);

    // R1 R10: write every address with bit 4 clear except the reset address
    for (int a = 0; a < 64; a++) begin
      if (a[4] || a == 4) continue;
      frame(6'(a), 8'((a * 29 + 7) ^ 8'h5A), 0, 8'h00);
    end
    // R4: read-request frames carrying data leave registers alone
    frame(6'h31, 8'h00, 0, 8'h00);
    pend = 1; pexp = rdval(6'h31);
    frame(6'h13, 8'hFF, pend, pexp);
    pexp = rdval(6'h13);

    // R5 R6 R9 R10: chained read-back of all 64 addresses
    for (int a = 0; a < 64; a++) begin
      frame(6'(a) | 6'h10, 8'hA5, 1, pexp);
      pexp = rdval(a);
    end
    frame(6'h00, 8'h3C, 1, pexp);

    // R8: broadcasts, then read back each member
    frame(6'h23, 8'h6E, 0, 8'h00);
    frame(6'h2B, 8'h91, 0, 8'h00);
    pend = 0;
    for (int a = 32; a < 44; a++) begin
      frame(6'(a) | 6'h10, 8'h00, pend, pexp);
      pend = 1; pexp = rdval(a);
    end
    // R9: write to revision ignored
    frame(6'h07, 8'h00, pend, pexp);
    frame(6'h17, 8'h00, 0, 8'h00);
    pexp = rdval(7);
    // R7: software reset, checked while read-back of revision is sent
    frame(6'h04, 8'hC3, 1, pexp);
    pend = 0;
    for (int a = 0; a < 64; a++) begin
      if (!writable(a)) continue;
      frame(6'(a) | 6'h10, 8'h00, pend, pexp);
      pend = 1; pexp = rdval(a);
    end
    frame(6'h00, 8'h00, 1, pexp);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule